// File: doc/BRIEF.md
# Serially Programmed Clock Fan-out Enable Controller

This block fans one reference clock out to thirteen output copies and lets a host switch each copy on or off over a two-wire serial bus. The bus side is a slave at the fixed 7-bit address 7'b1101001, so a write transfer opens with address byte 0xD2 and a read with 0xD3. SCL and SDA are sampled by a system clock through two-flop synchronizers. The slave drives SDA only by pulling it low, via an open-drain enable. START and STOP are recognised as SDA edges while SCL is high.

A write carries two leading bytes that the slave acknowledges and then throws away. Every later data byte is stored into the control registers, starting at register 0 and counting upward. A read first returns a fixed byte-count value of 0x09, then the registers from register 0 upward, then 0x00 for every index past the last register. The bus engine is a single state machine. Its states are ST_IDLE, ST_ADDR (shifting in the address), ST_ADDR_ACK, ST_WR_BYTE, ST_WR_ACK, ST_RD_BYTE and ST_RD_ACK. It moves through them as follows:

- ST_IDLE goes to ST_ADDR on START.
- ST_ADDR goes to ST_ADDR_ACK on a matching address. On any other address it goes back to ST_IDLE.
- ST_ADDR_ACK goes to ST_WR_BYTE or ST_RD_BYTE, as the direction bit selects.
- ST_WR_BYTE and ST_WR_ACK alternate.
- ST_RD_BYTE goes to ST_RD_ACK. ST_RD_ACK goes back to ST_RD_BYTE when the master acknowledges, and to ST_IDLE when it does not.
- START from any state goes to ST_ADDR, and STOP from any state goes to ST_IDLE.

Each output enable is carried into the reference-clock domain by flops clocked on the falling edge of the reference clock. An enable therefore changes only while the reference clock is low, so a switched output never produces a shortened pulse. A test input forces every output to high impedance.

Top module: `clkfan_serial_ctrl`

## Requirements
- R1: Address bytes 0xD2 and 0xD3 are acknowledged (SDA pulled low in the ninth clock). Any other address byte is left unacknowledged and the slave keeps SDA released until the next START.
- R2: In a write, the two bytes after the address are acknowledged and discarded. The following data bytes land in register 0, then register 1, then register 2.
- R3: A read returns 0x09 first, then registers 0, 1 and 2 in that order, then 0x00 for every later byte.
- R4: If the master does not acknowledge a read byte, the transfer ends and the slave releases SDA.
- R5: After reset all three registers hold 0xFF and all thirteen outputs toggle with the reference clock.
- R6: Register bits map to outputs as follows, where a 1 enables the output:
  - register 0: bits 3..0 drive outputs 3..0, and bits 7 and 6 drive outputs 5 and 4;
  - register 1: bits 1 and 0 drive outputs 7 and 6, and bits 7..4 drive outputs 11..8;
  - register 2: bit 6 drives output 12.
- R7: Reserved bits drive no output: bits 5 and 4 of register 0, bits 3 and 2 of register 1, and every bit of register 2 except bit 6. A read returns the value last written to them.
- R8: Data bytes written past register 2 are acknowledged but change no register.
- R9: A disabled output stays low. The applied enable changes only while the reference clock is low.
- R10: While test_hiz is 1, every clk_oe bit is 0 and every clk_out bit is 0.
- R11: A START at any point, including in the middle of a byte, returns the slave to address reception. The slave changes SDA only while SCL is low, except when a STOP or START releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| ref_clk | input | 1 | Reference clock that is fanned out |
| test_hiz | input | 1 | 1 puts all clock outputs in high impedance |
| clk_out | output | 13 | Gated copies of ref_clk |
| clk_oe | output | 13 | Output-driver enables for clk_out |

## Verification
Two functions can collide in the same cycle. The first pair is a register commit and a reference-clock high phase. The bench writes enables that switch outputs off and on while ref_clk runs freely at a rate unrelated to the system clock, so commits land in both phases. Each output is then judged against the expected enable at points in the high phase and in the low phase, and any enable change seen while ref_clk is high is flagged. The second pair is a START and a byte still being received. The bench breaks off a write after three data bits with a repeated START and checks two things: that the following read is answered with 0x09, and that no register took the partial byte.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

    localparam int NUM_CLK = 13;
    localparam int NUM_REG = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } bus_state_e;

    // Irregular bit-to-output map; reserved bits are simply not used.
    function automatic logic [NUM_CLK-1:0] regs_to_enables(input logic [NUM_REG-1:0][7:0] r);
        logic [NUM_CLK-1:0] e;
        e[3:0]  = r[0][3:0];
        e[5:4]  = r[0][7:6];
        e[7:6]  = r[1][1:0];
        e[11:8] = r[1][7:4];
        e[12]   = r[2][6];
        return e;
    endfunction

endpackage

// File: rtl/clkfan_bus_sync.sv
module clkfan_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/clkfan_bus_fsm.sv
module clkfan_bus_fsm
    import clkfan_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101001,
    parameter logic [7:0] BCOUNT   = 8'h09,
    parameter int         IDX_W    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sda_s,
    input  logic                     scl_rise,
    input  logic                     scl_fall,
    input  logic                     start_det,
    input  logic                     stop_det,
    output logic                     sda_oe,
    output logic [NUM_REG-1:0][7:0]  regs
);

    localparam logic [3:0] LAST_BIT = 4'd8;

    bus_state_e              state_q, state_d;
    logic [3:0]              cnt_q;
    logic [7:0]              shreg_q;
    logic [7:0]              tx_q;
    logic [IDX_W-1:0]        idx_q;
    logic [IDX_W-1:0]        nxt_idx;
    logic [7:0]              nxt_byte;
    logic                    rw_q;
    logic                    nack_q;
    logic                    byte_done;

    assign byte_done = scl_fall && (cnt_q == LAST_BIT);

    always_comb begin
        nxt_idx  = (idx_q == '1) ? idx_q : idx_q + 1'b1;
        nxt_byte = '0;
        for (int k = 0; k < NUM_REG; k++)
            if (int'(nxt_idx) == k + 1) nxt_byte = regs[k];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = ST_IDLE;
            ST_ADDR:     if (byte_done) state_d = (shreg_q[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
            ST_ADDR_ACK: if (scl_fall)  state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
            ST_WR_BYTE:  if (byte_done) state_d = ST_WR_ACK;
            ST_WR_ACK:   if (scl_fall)  state_d = ST_WR_BYTE;
            ST_RD_BYTE:  if (byte_done) state_d = ST_RD_ACK;
            ST_RD_ACK:   if (scl_fall)  state_d = nack_q ? ST_IDLE : ST_RD_BYTE;
            default:     state_d = ST_IDLE;
        endcase
        if (stop_det)  state_d = ST_IDLE;
        if (start_det) state_d = ST_ADDR;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            tx_q    <= '0;
            idx_q   <= '0;
            rw_q    <= 1'b0;
            nack_q  <= 1'b0;
            sda_oe  <= 1'b0;
            regs    <= '1;
        end else if (start_det) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            sda_oe <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: sda_oe <= 1'b0;
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shreg_q <= {shreg_q[6:0], sda_s};
                        cnt_q   <= cnt_q + 1'b1;
                    end
                    if (byte_done) begin
                        cnt_q <= '0;
                        if (state_q == ST_ADDR) begin
                            sda_oe <= (shreg_q[7:1] == DEV_ADDR);
                            rw_q   <= shreg_q[0];
                        end else begin
                            sda_oe <= 1'b1;
                            for (int k = 0; k < NUM_REG; k++)
                                if (int'(idx_q) == k + 2) regs[k] <= shreg_q;
                            idx_q <= nxt_idx;
                        end
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    idx_q <= '0;
                    cnt_q <= '0;
                    if (rw_q) begin
                        tx_q   <= BCOUNT;
                        sda_oe <= ~BCOUNT[7];
                    end else begin
                        sda_oe <= 1'b0;
                    end
                end
                ST_WR_ACK: if (scl_fall) sda_oe <= 1'b0;
                ST_RD_BYTE: begin
                    if (scl_rise) cnt_q <= cnt_q + 1'b1;
                    if (byte_done) begin
                        sda_oe <= 1'b0;
                        cnt_q  <= '0;
                    end else if (scl_fall) begin
                        sda_oe <= ~tx_q[6];
                        tx_q   <= {tx_q[6:0], 1'b0};
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) nack_q <= sda_s;
                    if (scl_fall && !nack_q) begin
                        idx_q  <= nxt_idx;
                        tx_q   <= nxt_byte;
                        sda_oe <= ~nxt_byte[7];
                    end
                end
                default: sda_oe <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/clkfan_gate_bank.sv
module clkfan_gate_bank #(
    parameter int N_OUT = 13
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             test_hiz,
    input  logic [N_OUT-1:0] en_req,
    output logic [N_OUT-1:0] en_live,
    output logic [N_OUT-1:0] clk_out,
    output logic [N_OUT-1:0] clk_oe
);

    for (genvar g = 0; g < N_OUT; g++) begin : g_cell
        logic meta_q;
        logic hold_q;
        // falling-edge capture: enable only moves while ref_clk is low
        always_ff @(negedge ref_clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                hold_q <= 1'b1;
            end else begin
                meta_q <= en_req[g];
                hold_q <= meta_q;
            end
        end
        assign en_live[g] = hold_q;
        assign clk_out[g] = ref_clk & hold_q & ~test_hiz;
        assign clk_oe[g]  = ~test_hiz;
    end

endmodule

// File: rtl/clkfan_serial_ctrl.sv
module clkfan_serial_ctrl
    import clkfan_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101001,
    parameter logic [7:0] BCOUNT   = 8'h09,
    parameter int         SYNC_LEN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic               ref_clk,
    input  logic               test_hiz,
    output logic [NUM_CLK-1:0] clk_out,
    output logic [NUM_CLK-1:0] clk_oe
);

    logic                    scl_s, sda_s, scl_rise, scl_fall;
    logic                    start_det, stop_det;
    logic [NUM_REG-1:0][7:0] regs;
    logic [NUM_CLK-1:0]      en_req;
    logic [NUM_CLK-1:0]      en_live;

    clkfan_bus_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    clkfan_bus_fsm #(.DEV_ADDR(DEV_ADDR), .BCOUNT(BCOUNT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .regs      (regs)
    );

    assign en_req = regs_to_enables(regs);

    clkfan_gate_bank #(.N_OUT(NUM_CLK)) u_gate (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .test_hiz (test_hiz),
        .en_req   (en_req),
        .en_live  (en_live),
        .clk_out  (clk_out),
        .clk_oe   (clk_oe)
    );

endmodule

// File: rtl/clkfan_serial_ctrl_chk.sv
module clkfan_serial_ctrl_chk #(
    parameter int N = 13
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scl_s,
    input logic         start_det,
    input logic         stop_det,
    input logic         sda_oe,
    input logic         ref_clk,
    input logic         test_hiz,
    input logic [N-1:0] en_live,
    input logic [N-1:0] clk_out,
    input logic [N-1:0] clk_oe
);

    // R11: SDA drive moves only while SCL is low, unless a START/STOP released it
    p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> (!scl_s || $past(stop_det) || $past(start_det)));

    // R4: after STOP the line is released
    p_stop_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R10: test mode floats and silences every output
    p_hiz_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        test_hiz |-> (clk_oe == '0) && (clk_out == '0));

    // R9: an output with its enable off never goes high
    p_disabled_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out & ~en_live) == '0);

    // R9: applied enables change only in the low phase of ref_clk
    always @(en_live) begin
        if (rst_n) p_en_change_low_r9: assert (!ref_clk);
    end

endmodule

bind clkfan_serial_ctrl clkfan_serial_ctrl_chk #(.N(13)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .ref_clk   (ref_clk),
    .test_hiz  (test_hiz),
    .en_live   (en_live),
    .clk_out   (clk_out),
    .clk_oe    (clk_oe)
);

// File: tb/test_clkfan_serial_ctrl.sv
module test_clkfan_serial_ctrl;

    localparam int Q = 8;

    logic        clk = 0, rst_n = 0, scl = 1, sda_m = 1, ref_clk = 0, test_hiz = 0;
    logic        sda_oe;
    logic [12:0] clk_out, clk_oe;
    wire         sda_line = sda_m & ~sda_oe;

    typedef struct { string req; int unsigned val; } item_t;
    item_t exp_q[$];
    int unsigned obs_q[$];
    int vectors = 0, fails = 0, cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;
    always #7  ref_clk = ~ref_clk;

    clkfan_serial_ctrl i_clkfan_serial_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .ref_clk(ref_clk), .test_hiz(test_hiz), .clk_out(clk_out), .clk_oe(clk_oe));

    // scoreboard monitor
    initial forever begin
        wait (obs_q.size() > 0);
        begin
            item_t e;
            int unsigned o;
            o = obs_q.pop_front();
            e = exp_q.pop_front();
            vectors++;
            if (o != e.val) begin
                fails++;
                $display("FAIL %s actual %0h expected %0h", e.req, o, e.val);
            end
        end
    end

    task automatic expect_item(input string req, input int unsigned v);
        exp_q.push_back('{req, v});
    endtask

    task automatic observe(input int unsigned v);
        obs_q.push_back(v);
        #1;
    endtask

    task automatic waitq(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1; waitq(Q); scl = 1; waitq(Q);
        sda_m = 0; waitq(Q); scl = 0; waitq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 0; waitq(Q); scl = 1; waitq(Q); sda_m = 1; waitq(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; waitq(Q); scl = 1; waitq(2*Q); scl = 0; waitq(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1; waitq(Q); scl = 1; waitq(Q); #3 b = sda_line; waitq(Q); scl = 0; waitq(Q);
    endtask

    task automatic send(input string req, input logic [7:0] d, input logic exp_ack_bit);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        expect_item(req, exp_ack_bit);
        observe(a);
    endtask

    task automatic recv(input string req, input logic [7:0] exp_d, input logic last);
        logic [7:0] d;
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
        put_bit(last);
        expect_item(req, exp_d);
        observe(d);
    endtask

    function automatic logic [12:0] map_en(input logic [7:0] r0, r1, r2);
        return {r2[6], r1[7:4], r1[1:0], r0[7:6], r0[3:0]};
    endfunction

    task automatic check_clocks(input string req, input logic [12:0] en);
        repeat (6) @(negedge ref_clk);
        for (int k = 0; k < 3; k++) begin
            @(posedge ref_clk); #3;
            expect_item(req, en); observe(clk_out);
            @(negedge ref_clk); #3;
            expect_item(req, 0); observe(clk_out);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                fails++;
                $display("FAIL watchdog actual %0d expected <150000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    initial begin
        waitq(4); rst_n = 1; waitq(4);

        // R5: reset state
        expect_item("R5 oe", 13'h1fff); observe(clk_oe);
        expect_item("R5 sda", 0); observe(sda_oe);
        check_clocks("R5 clocks", 13'h1fff);

        // R1/R3/R5: initial read
        bus_start;
        send("R1 addr rd", 8'hD3, 0);
        recv("R3 count", 8'h09, 0);
        recv("R5 reg0", 8'hFF, 0);
        recv("R5 reg1", 8'hFF, 0);
        recv("R5 reg2", 8'hFF, 0);
        recv("R3 past end", 8'h00, 1);
        waitq(Q);
        expect_item("R4 released", 0); observe(sda_oe);
        bus_stop;

        // R2/R6/R7/R9: write pattern with reserved bits and disables
        bus_start;
        send("R1 addr wr", 8'hD2, 0);
        send("R2 cmd ack", 8'h5A, 0);
        send("R2 cnt ack", 8'h77, 0);
        send("R2 d0 ack", 8'h35, 0);
        send("R2 d1 ack", 8'hA6, 0);
        send("R2 d2 ack", 8'h40, 0);
        bus_stop;
        check_clocks("R6 R9 map", map_en(8'h35, 8'hA6, 8'h40));

        bus_start;
        send("R1 addr rd", 8'hD3, 0);
        recv("R3 count", 8'h09, 0);
        recv("R7 reg0", 8'h35, 0);
        recv("R7 reg1", 8'hA6, 0);
        recv("R7 reg2", 8'h40, 1);
        bus_stop;

        // R8: overrun write
        bus_start;
        send("R1 addr wr", 8'hD2, 0);
        send("R2 cmd", 8'h00, 0);
        send("R2 cnt", 8'h05, 0);
        send("R2 d0", 8'hCB, 0);
        send("R2 d1", 8'h5C, 0);
        send("R2 d2", 8'hBF, 0);
        send("R8 extra ack", 8'h00, 0);
        send("R8 extra ack", 8'h12, 0);
        bus_stop;
        check_clocks("R6 map2", map_en(8'hCB, 8'h5C, 8'hBF));
        bus_start;
        send("R1 addr rd", 8'hD3, 0);
        recv("R3 count", 8'h09, 0);
        recv("R8 reg0", 8'hCB, 0);
        recv("R8 reg1", 8'h5C, 0);
        recv("R8 reg2", 8'hBF, 0);
        recv("R8 past end", 8'h00, 1);
        bus_stop;

        // R1: foreign addresses
        bus_start;
        send("R1 nack A4", 8'hA4, 1);
        bus_stop;
        bus_start;
        send("R1 nack D0", 8'hD0, 1);
        expect_item("R1 silent", 0); observe(sda_oe);
        bus_stop;

        // R11: START breaks a data byte
        bus_start;
        send("R1 addr wr", 8'hD2, 0);
        send("R2 cmd", 8'h00, 0);
        send("R2 cnt", 8'h01, 0);
        put_bit(0); put_bit(0); put_bit(0);
        bus_start;
        send("R11 addr after restart", 8'hD3, 0);
        recv("R11 count", 8'h09, 0);
        recv("R11 reg0 kept", 8'hCB, 1);
        bus_stop;

        // R9: all off then all on
        bus_start;
        send("R1 addr wr", 8'hD2, 0);
        send("R2 cmd", 8'h00, 0);
        send("R2 cnt", 8'h03, 0);
        send("R9 d0", 8'h00, 0);
        send("R9 d1", 8'h00, 0);
        send("R9 d2", 8'h00, 0);
        bus_stop;
        check_clocks("R9 all off", 13'h0000);
        bus_start;
        send("R1 addr wr", 8'hD2, 0);
        send("R2 cmd", 8'h00, 0);
        send("R2 cnt", 8'h03, 0);
        send("R9 d0", 8'hFF, 0);
        send("R9 d1", 8'hFF, 0);
        send("R9 d2", 8'hFF, 0);
        bus_stop;
        check_clocks("R9 all on", 13'h1fff);

        // R10: test high impedance
        test_hiz = 1;
        @(posedge ref_clk); #3;
        expect_item("R10 oe", 0); observe(clk_oe);
        expect_item("R10 out", 0); observe(clk_out);
        test_hiz = 0;
        check_clocks("R10 restore", 13'h1fff);

        wait (obs_q.size() == 0);
        #5;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule